// File: doc/BRIEF.md
# Predicated Execution Gate with Status Flags

The block keeps the four arithmetic status flags of a processor pipeline (negative, zero, carry, signed overflow) and decides, once per instruction, whether that instruction is allowed to take effect. Each instruction carries a 4-bit condition code. The code is tested against the flags held at that moment, and the result drives a single enable line that the rest of the pipeline uses to commit or drop the instruction.

The same instruction can also rewrite the flags. It may do so only when it actually executes. Compare-class instructions always write the flags. Ordinary data-processing instructions write them only when their set-flags bit is 1. All other instructions never write them. The new N and Z come from the ALU result. C and V come from the adder for arithmetic operations. For logical operations C comes from the shifter and V keeps its old value. One instruction is presented per clock cycle. The enable is combinational from the current inputs and the stored flags, and a flag write takes effect at the next rising edge.

Top module: `predicate_flag_unit`

## Requirements
- R1: After reset the flag output `flags_o` is 4'b0000 (bit 3 N, bit 2 Z, bit 1 C, bit 0 V).
- R2: Condition codes 0 to 7 pass when, in order: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: Code 10 passes when N==V, code 11 when N!=V, code 12 when Z=0 and N==V, and code 13 when Z=1 or N!=V.
- R5: Code 14 always passes and code 15 never passes, whatever the flags.
- R6: A data-processing instruction (class 2'b00) writes the flags only if `set_flags_i` is 1.
- R7: A compare instruction (class 2'b01) that passes writes the flags even when `set_flags_i` is 0.
- R8: An instruction whose condition fails leaves the flags unchanged, even with `set_flags_i` at 1 or class compare.
- R9: An instruction of class 2'b10 or 2'b11 never changes the flags.
- R10: On a flag write, N takes the result's top bit and Z is 1 exactly when the result is all zero.
- R11: On a flag write with `logical_i`=0, C takes `add_carry_i` and V takes `add_ovf_i`.
- R12: On a flag write with `logical_i`=1, C takes `shift_carry_i` and V keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 4 | Condition code of the current instruction |
| iclass_i | input | 2 | 00 data processing, 01 compare, 10/11 other |
| set_flags_i | input | 1 | Set-flags bit of the instruction |
| logical_i | input | 1 | 1 for a logical ALU operation, 0 for arithmetic |
| result_i | input | DATA_W | ALU result |
| add_carry_i | input | 1 | Adder carry-out |
| add_ovf_i | input | 1 | Adder signed overflow |
| shift_carry_i | input | 1 | Shifter carry-out |
| exec_o | output | 1 | Instruction may execute |
| flags_o | output | 4 | Stored flags {N, Z, C, V} |

## Verification
The condition test and the flag write can fall in the same cycle. An instruction is predicated on the flags it is about to replace. The bench provokes this with a compare conditioned on Z=1, issued while Z is 1, whose result is non-zero. The bench expects the enable to be high in that cycle because the old flags decide it. After the edge Z must read 0, and a following instruction with the same condition must then be blocked. The reverse case is also driven: a failing condition on an instruction that requests a flag write must leave the flags as they were.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

    localparam int COND_W  = 4;
    localparam int NCODES  = 1 << COND_W;
    localparam int CLASS_W = 2;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef enum logic [CLASS_W-1:0] {
        IC_DATA  = 2'd0,
        IC_CMP   = 2'd1,
        IC_OTHER = 2'd2,
        IC_SPARE = 2'd3
    } iclass_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic cond_holds(cond_e code, flags_t f);
        logic r;
        case (code)
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_HS:   r = f.c;
            CC_LO:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            CC_AL:   r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfu_cond_eval.sv
module pfu_cond_eval
    import pfu_pkg::*;
(
    input  flags_t            flags_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              pass_o
);

    logic [NCODES-1:0] hit_vec;

    for (genvar k = 0; k < NCODES; k++) begin : g_code
        assign hit_vec[k] = cond_holds(cond_e'(k), flags_i);
    end

    assign pass_o = hit_vec[cond_i];

endmodule

// File: rtl/pfu_flag_calc.sv
module pfu_flag_calc
    import pfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              add_carry_i,
    input  logic              add_ovf_i,
    input  logic              shift_carry_i,
    input  logic              logical_i,
    input  flags_t            cur_i,
    output flags_t            cand_o
);

    localparam int MSB = DATA_W - 1;

    always_comb begin
        cand_o.n = result_i[MSB];
        cand_o.z = (result_i == '0);
        if (logical_i) begin
            cand_o.c = shift_carry_i;
            cand_o.v = cur_i.v;
        end else begin
            cand_o.c = add_carry_i;
            cand_o.v = add_ovf_i;
        end
    end

endmodule

// File: rtl/pfu_update_ctl.sv
module pfu_update_ctl
    import pfu_pkg::*;
(
    input  logic [CLASS_W-1:0] iclass_i,
    input  logic               set_flags_i,
    input  logic               pass_i,
    output logic               wr_en_o
);

    iclass_e cls;

    always_comb begin
        cls = iclass_e'(iclass_i);
        wr_en_o = 1'b0;
        if (pass_i) begin
            case (cls)
                IC_CMP:  wr_en_o = 1'b1;
                IC_DATA: wr_en_o = set_flags_i;
                default: wr_en_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/predicate_flag_unit.sv
module predicate_flag_unit
    import pfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cond_i,
    input  logic [1:0]        iclass_i,
    input  logic              set_flags_i,
    input  logic              logical_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              add_carry_i,
    input  logic              add_ovf_i,
    input  logic              shift_carry_i,
    output logic              exec_o,
    output logic [3:0]        flags_o
);

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t state_d, state_q;
    flags_t cand;
    logic   pass;
    logic   wr_en;

    pfu_cond_eval i_cond_eval (
        .flags_i (state_q.flags),
        .cond_i  (cond_i),
        .pass_o  (pass)
    );

    pfu_flag_calc #(.DATA_W(DATA_W)) i_flag_calc (
        .result_i      (result_i),
        .add_carry_i   (add_carry_i),
        .add_ovf_i     (add_ovf_i),
        .shift_carry_i (shift_carry_i),
        .logical_i     (logical_i),
        .cur_i         (state_q.flags),
        .cand_o        (cand)
    );

    pfu_update_ctl i_update_ctl (
        .iclass_i    (iclass_i),
        .set_flags_i (set_flags_i),
        .pass_i      (pass),
        .wr_en_o     (wr_en)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.flags = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign exec_o  = pass;
    assign flags_o = state_q.flags;

    AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'd14) |-> exec_o); // R5

    AST_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'd15) |-> !exec_o); // R5

    AST_DATA_NO_S_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (iclass_i == 2'd0 && !set_flags_i) |=> $stable(flags_o)); // R6

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |=> $stable(flags_o)); // R8

    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        iclass_i[1] |=> $stable(flags_o)); // R9

    AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && iclass_i == 2'd1) |=> !(flags_o[3] && flags_o[2])); // R10

    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && logical_i) |=> (flags_o[0] == $past(flags_o[0]))); // R12

endmodule

// File: tb/test_predicate_flag_unit.sv
`timescale 1ns/1ps
module test_predicate_flag_unit;

    localparam int  CLK_PERIOD = 10;
    localparam int  DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cond_i = 4'd14;
    logic [1:0]    iclass_i = 2'd2;
    logic          set_flags_i = 1'b0;
    logic          logical_i = 1'b0;
    logic [DW-1:0] result_i = '0;
    logic          add_carry_i = 1'b0;
    logic          add_ovf_i = 1'b0;
    logic          shift_carry_i = 1'b0;
    logic          exec_o;
    logic [3:0]    flags_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    predicate_flag_unit #(.DATA_W(DW)) i_predicate_flag_unit (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .iclass_i(iclass_i),
        .set_flags_i(set_flags_i), .logical_i(logical_i), .result_i(result_i),
        .add_carry_i(add_carry_i), .add_ovf_i(add_ovf_i),
        .shift_carry_i(shift_carry_i), .exec_o(exec_o), .flags_o(flags_o)
    );

    function automatic logic ref_pass(logic [3:0] cc, logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0: return z;          4'd1: return !z;
            4'd2: return c;          4'd3: return !c;
            4'd4: return n;          4'd5: return !n;
            4'd6: return v;          4'd7: return !v;
            4'd8: return c && !z;    4'd9: return !c || z;
            4'd10: return n == v;    4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] cc, logic [1:0] cls, logic s, logic lg,
                         logic [DW-1:0] res, logic ac, logic av, logic sc);
        @(negedge clk);
        cond_i = cc; iclass_i = cls; set_flags_i = s; logical_i = lg;
        result_i = res; add_carry_i = ac; add_ovf_i = av; shift_carry_i = sc;
        #1;
    endtask

    task automatic commit();
        @(posedge clk);
        #1;
        iclass_i = 2'd2; cond_i = 4'd14; set_flags_i = 1'b0;
    endtask

    task automatic set_flags(logic [3:0] f);
        logic [DW-1:0] res;
        res = f[2] ? '0 : (f[3] ? 32'h8000_0000 : 32'h1);
        issue(4'd14, 2'd1, 1'b0, 1'b0, res, f[1], f[0], 1'b0);
        commit();
    endtask

    task automatic t_reset();
        check("R1 reset flags", flags_o, 4'b0000);
        issue(4'd14, 2'd2, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        check("R5 AL after reset", {3'b0, exec_o}, 4'd1);
        issue(4'd0, 2'd2, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        check("R2 EQ after reset", {3'b0, exec_o}, 4'd0);
    endtask

    task automatic t_cond_matrix();
        for (int f = 0; f < 16; f++) begin
            if (f[3] && f[2]) continue;
            set_flags(4'(f));
            check("R10 flags loaded", flags_o, 4'(f));
            for (int cc = 0; cc < 16; cc++) begin
                issue(4'(cc), 2'd2, 1'b1, 1'b0, 32'h5, 1'b1, 1'b1, 1'b1);
                if (cc < 8)       check("R2 cond", {3'b0, exec_o}, {3'b0, ref_pass(4'(cc), 4'(f))});
                else if (cc < 10) check("R3 cond", {3'b0, exec_o}, {3'b0, ref_pass(4'(cc), 4'(f))});
                else if (cc < 14) check("R4 cond", {3'b0, exec_o}, {3'b0, ref_pass(4'(cc), 4'(f))});
                else              check("R5 cond", {3'b0, exec_o}, {3'b0, ref_pass(4'(cc), 4'(f))});
            end
            commit();
            check("R9 other class no write", flags_o, 4'(f));
        end
    endtask

    task automatic t_data_sbit();
        set_flags(4'b0100);
        issue(4'd14, 2'd0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b1, 1'b0);
        commit();
        check("R6 data no S keeps flags", flags_o, 4'b0100);
        issue(4'd14, 2'd0, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b1, 1'b0);
        commit();
        check("R6 data with S writes", flags_o, 4'b1011);
    endtask

    task automatic t_compare();
        set_flags(4'b0000);
        issue(4'd14, 2'd1, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
        commit();
        check("R7 compare without S writes", flags_o, 4'b0110);
    endtask

    task automatic t_fail_hold();
        set_flags(4'b0100);
        issue(4'd1, 2'd0, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b1, 1'b0);
        check("R8 NE fails with Z", {3'b0, exec_o}, 4'd0);
        commit();
        check("R8 failed data keeps flags", flags_o, 4'b0100);
        issue(4'd15, 2'd1, 1'b0, 1'b0, 32'h1, 1'b1, 1'b1, 1'b0);
        commit();
        check("R8 never-code compare keeps flags", flags_o, 4'b0100);
    endtask

    task automatic t_other();
        set_flags(4'b1010);
        issue(4'd14, 2'd2, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
        commit();
        check("R9 class 2 keeps flags", flags_o, 4'b1010);
        issue(4'd14, 2'd3, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
        commit();
        check("R9 class 3 keeps flags", flags_o, 4'b1010);
    endtask

    task automatic t_nz();
        issue(4'd14, 2'd1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        commit();
        check("R10 zero result", flags_o, 4'b0100);
        issue(4'd14, 2'd1, 1'b0, 1'b0, 32'h8000_0001, 1'b0, 1'b0, 1'b0);
        commit();
        check("R10 negative result", flags_o, 4'b1000);
        issue(4'd14, 2'd1, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
        commit();
        check("R10 positive result", flags_o, 4'b0000);
    endtask

    task automatic t_arith();
        set_flags(4'b0000);
        issue(4'd14, 2'd1, 1'b0, 1'b0, 32'h3, 1'b1, 1'b0, 1'b0);
        commit();
        check("R11 adder carry", flags_o, 4'b0010);
        issue(4'd14, 2'd1, 1'b0, 1'b0, 32'h3, 1'b0, 1'b1, 1'b1);
        commit();
        check("R11 adder overflow, shifter ignored", flags_o, 4'b0001);
    endtask

    task automatic t_logic();
        set_flags(4'b0001);
        issue(4'd14, 2'd0, 1'b1, 1'b1, 32'h4, 1'b0, 1'b0, 1'b1);
        commit();
        check("R12 shifter carry, V kept 1", flags_o, 4'b0011);
        set_flags(4'b0010);
        issue(4'd14, 2'd1, 1'b0, 1'b1, 32'h0, 1'b1, 1'b1, 1'b0);
        commit();
        check("R12 shifter carry 0, V kept 0", flags_o, 4'b0100);
    endtask

    task automatic t_same_cycle();
        set_flags(4'b0100);
        issue(4'd0, 2'd1, 1'b0, 1'b0, 32'h9, 1'b0, 1'b0, 1'b0);
        check("R2 EQ decided on old flags", {3'b0, exec_o}, 4'd1);
        commit();
        check("R7 compare wrote new flags", flags_o, 4'b0000);
        issue(4'd0, 2'd0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        check("R2 EQ now blocked", {3'b0, exec_o}, 4'd0);
        commit();
        check("R8 blocked follow-up keeps flags", flags_o, 4'b0000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_cond_matrix();
        t_data_sbit();
        t_compare();
        t_fail_hold();
        t_other();
        t_nz();
        t_arith();
        t_logic();
        t_same_cycle();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule